// File: doc/BRIEF.md
# Receive Descriptor Fill Engine

This block places incoming frames into host-owned receive descriptors. Software posts the offsets of free descriptors through a 32-bit register write port, and they are held in a small first-in first-out queue. When the first byte of a frame arrives on the byte stream, the engine takes the oldest free offset. Each payload byte goes into receive memory after a fixed 24-byte header. After the last byte, the engine writes the header fields. The status word holding the received flag is written last, so software polling the flag never sees it before the data.

The receive stream uses valid/ready. A byte moves on a clock edge where both `rx_valid` and `rx_ready` are high. The engine lowers `rx_ready` only while it writes a header, for a fixed 20 cycles after each stored frame. The source must hold its byte, last flag and error code stable while `rx_ready` is low. Between frames `rx_ready` stays high, and a frame that finds no free descriptor is still accepted at full rate and then thrown away. The memory side is a plain write port, one byte per cycle, with no back-pressure. Five event counters are plain outputs, and each can be cleared through the register port.

Top module: `rx_desc_fill`

## Requirements
- R1: A write to register address 0 with bit 31 set queues bits 23:0 as a free descriptor offset. A write with bit 31 clear is ignored, and so is a post made while 8 offsets are already queued.
- R2: A write of any value to register address 1 empties the free queue, so the next frame is dropped.
- R3: Payload byte i of a stored frame is written to address base+24+i, one memory write per byte, in arrival order.
- R4: After the last byte, header bytes 8 to 23 are written. Bytes 8 (low) and 9 (high) hold the length: 24 plus the stored byte count, which includes the 4-byte FCS, in 12 bits. Bytes 10 and 11 hold the port code 0x0001, low byte first. Bytes 12 to 23 hold zero.
- R5: The status bytes at base+4 to base+7 are written after every payload and header byte: byte 4 is 0x01 and bytes 5 to 7 are 0x00. Bytes base+0 to base+3 are never written.
- R6: `rx_ready` is high out of reset and between frames. It is low for exactly 20 cycles after the last byte of each stored frame, and it is never lowered for any other reason.
- R7: A frame that starts while the free queue is empty is accepted in full, causes no memory write, and adds one to the dropped counter.
- R8: A frame longer than 2024 bytes keeps only its first 2024 bytes, gets the length value 2048, and adds one to the receive error counter.
- R9: `rx_err` is sampled with the last byte. Code 1 counts a CRC error, code 2 a framing error and code 3 a receive error. The frame is still stored, and every stored frame adds one to the 32-bit frame counter.
- R10: The four 8-bit counters (receive error, CRC, framing, dropped) saturate at 255.
- R11: Writing zero to address 2 (frames), 3 (receive errors), 4 (CRC), 5 (framing) or 6 (dropped) clears that counter. A nonzero write to those addresses leaves the counter unchanged.
- R12: Free descriptors are used in the order they were posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine can accept a byte |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of a frame |
| rx_err | input | 2 | Error code, sampled with the last byte |
| mem_we | output | 1 | Receive memory write enable |
| mem_addr | output | 24 | Receive memory byte address |
| mem_wdata | output | 8 | Receive memory write byte |
| frame_count | output | 32 | Stored frame count |
| rxerr_count | output | 8 | Receive error count |
| crc_count | output | 8 | CRC error count |
| align_count | output | 8 | Framing error count |
| drop_count | output | 8 | Dropped frame count |

## Verification
The checks assume that every posted offset is a multiple of 0x800, so that the low 11 address bits identify the field inside a descriptor. They also assume that the source holds its byte steady while `rx_ready` is low. The bench posts only 0x800-aligned offsets and drives each byte at a falling edge. It keeps that byte until a falling edge where `rx_ready` is high, and only the next rising edge consumes it. Register writes are issued only when no frame is in flight, so the bench's model of the free queue matches the design's queue at every frame start.

// File: rtl/rxfill_pkg.sv
package rxfill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_SKIP,
    ST_HDR
  } fill_state_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_CRC   = 2'd1,
    ERR_ALIGN = 2'd2,
    ERR_PHY   = 2'd3
  } rx_err_e;

  localparam logic [2:0] REG_POST      = 3'd0;
  localparam logic [2:0] REG_QFLUSH    = 3'd1;
  localparam logic [2:0] REG_CLR_FRM   = 3'd2;
  localparam logic [2:0] REG_CLR_RXERR = 3'd3;
  localparam logic [2:0] REG_CLR_CRC   = 3'd4;
  localparam logic [2:0] REG_CLR_ALIGN = 3'd5;
  localparam logic [2:0] REG_CLR_DROP  = 3'd6;

  localparam int CI_RXERR = 0;
  localparam int CI_CRC   = 1;
  localparam int CI_ALIGN = 2;
  localparam int CI_DROP  = 3;
  localparam int N_SAT    = 4;

endpackage

// File: rtl/rxfill_free_q.sv
module rxfill_free_q #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] slots [DEPTH];
  logic [AW:0]  wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign head  = slots[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) slots[wptr[AW-1:0]] <= push_data;
  end
endmodule

// File: rtl/rxfill_counters.sv
module rxfill_counters #(
  parameter int NSAT  = 4,
  parameter int SAT_W = 8,
  parameter int TOT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSAT-1:0]            sat_inc,
  input  logic [NSAT-1:0]            sat_clr,
  input  logic                       tot_inc,
  input  logic                       tot_clr,
  output logic [NSAT-1:0][SAT_W-1:0] sat_val,
  output logic [TOT_W-1:0]           tot_val
);
  for (genvar g = 0; g < NSAT; g++) begin : g_sat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              sat_val[g] <= '0;
      else if (sat_clr[g])                     sat_val[g] <= '0;
      else if (sat_inc[g] && sat_val[g] != '1) sat_val[g] <= sat_val[g] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tot_val <= '0;
    else if (tot_clr) tot_val <= '0;
    else if (tot_inc) tot_val <= tot_val + 1'b1;
  end
endmodule

// File: rtl/rxfill_engine.sv
module rxfill_engine
  import rxfill_pkg::*;
#(
  parameter int          OFF_W       = 24,
  parameter int          HDR_BYTES   = 24,
  parameter int          PAYLOAD_MAX = 2024,
  parameter int          LEN_W       = 12,
  parameter logic [15:0] PORT_CODE   = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic [1:0]       rx_err,
  input  logic             q_empty,
  input  logic [OFF_W-1:0] q_head,
  output logic             q_pop,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             done_pulse,
  output logic [1:0]       done_err,
  output logic             done_trunc,
  output logic             drop_pulse
);
  localparam int CNT_W     = $clog2(PAYLOAD_MAX + 1);
  localparam int HDR_TAIL  = HDR_BYTES - 8;
  localparam int HDR_STEPS = HDR_TAIL + 4;
  localparam int IDX_W     = $clog2(HDR_STEPS);

  fill_state_e      state;
  logic [OFF_W-1:0] base;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] hdr_idx;
  logic [LEN_W-1:0] hdr_len;
  logic [7:0]       hoff;
  logic [7:0]       hbyte;
  logic             beat;

  assign rx_ready   = (state != ST_HDR);
  assign beat       = rx_valid && rx_ready;
  assign q_pop      = beat && (state == ST_IDLE) && !q_empty;
  assign hdr_len    = LEN_W'(HDR_BYTES) + LEN_W'(cnt);

  // Header walk: length/port/reserved/timestamp first, status word last
  always_comb begin
    if (hdr_idx < IDX_W'(HDR_TAIL)) hoff = 8'(hdr_idx) + 8'd8;
    else                            hoff = 8'(hdr_idx) - 8'(HDR_TAIL) + 8'd4;
    case (hoff)
      8'd4:    hbyte = 8'h01;
      8'd8:    hbyte = hdr_len[7:0];
      8'd9:    hbyte = 8'(hdr_len >> 8);
      8'd10:   hbyte = PORT_CODE[7:0];
      8'd11:   hbyte = PORT_CODE[15:8];
      default: hbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base       <= '0;
      cnt        <= '0;
      hdr_idx    <= '0;
      done_err   <= ERR_NONE;
      done_trunc <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done_pulse <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      done_pulse <= 1'b0;
      drop_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (beat) begin
            if (!q_empty) begin
              base       <= q_head;
              mem_we     <= 1'b1;
              mem_addr   <= q_head + OFF_W'(HDR_BYTES);
              mem_wdata  <= rx_data;
              cnt        <= CNT_W'(1);
              done_trunc <= 1'b0;
              if (rx_last) begin
                done_err <= rx_err;
                hdr_idx  <= '0;
                state    <= ST_HDR;
              end else begin
                state <= ST_DATA;
              end
            end else if (rx_last) begin
              drop_pulse <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (beat) begin
            if (cnt < CNT_W'(PAYLOAD_MAX)) begin
              mem_we    <= 1'b1;
              mem_addr  <= base + OFF_W'(HDR_BYTES) + OFF_W'(cnt);
              mem_wdata <= rx_data;
              cnt       <= cnt + 1'b1;
            end else begin
              done_trunc <= 1'b1;
            end
            if (rx_last) begin
              done_err <= rx_err;
              hdr_idx  <= '0;
              state    <= ST_HDR;
            end
          end
        end
        ST_SKIP: begin
          if (beat && rx_last) begin
            drop_pulse <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= base + OFF_W'(hoff);
          mem_wdata <= hbyte;
          if (hdr_idx == IDX_W'(HDR_STEPS - 1)) begin
            done_pulse <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            hdr_idx <= hdr_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_fill.sv
module rx_desc_fill
  import rxfill_pkg::*;
#(
  parameter int          OFF_W       = 24,
  parameter int          QDEPTH      = 8,
  parameter int          HDR_BYTES   = 24,
  parameter int          PAYLOAD_MAX = 2024,
  parameter int          LEN_W       = 12,
  parameter int          SAT_W       = 8,
  parameter int          TOT_W       = 32,
  parameter logic [15:0] PORT_CODE   = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic [1:0]       rx_err,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic [TOT_W-1:0] frame_count,
  output logic [SAT_W-1:0] rxerr_count,
  output logic [SAT_W-1:0] crc_count,
  output logic [SAT_W-1:0] align_count,
  output logic [SAT_W-1:0] drop_count
);
  logic             q_push, q_pop, q_flush, q_empty, q_full;
  logic [OFF_W-1:0] q_head;
  logic             done_pulse, done_trunc, drop_pulse;
  logic [1:0]       done_err;
  logic [N_SAT-1:0] sat_inc, sat_clr;
  logic [N_SAT-1:0][SAT_W-1:0] sat_val;
  logic             tot_clr;
  logic             zero_wr;
  logic             unused_post_bits;
  logic             unused_full;

  assign unused_post_bits = ^reg_wdata[30:OFF_W];
  assign unused_full      = q_full;

  assign q_push  = reg_we && (reg_addr == REG_POST) && reg_wdata[31];
  assign q_flush = reg_we && (reg_addr == REG_QFLUSH);
  assign zero_wr = reg_we && (reg_wdata == 32'd0);

  assign tot_clr           = zero_wr && (reg_addr == REG_CLR_FRM);
  assign sat_clr[CI_RXERR] = zero_wr && (reg_addr == REG_CLR_RXERR);
  assign sat_clr[CI_CRC]   = zero_wr && (reg_addr == REG_CLR_CRC);
  assign sat_clr[CI_ALIGN] = zero_wr && (reg_addr == REG_CLR_ALIGN);
  assign sat_clr[CI_DROP]  = zero_wr && (reg_addr == REG_CLR_DROP);

  assign sat_inc[CI_RXERR] = done_pulse && (done_trunc || done_err == ERR_PHY);
  assign sat_inc[CI_CRC]   = done_pulse && (done_err == ERR_CRC);
  assign sat_inc[CI_ALIGN] = done_pulse && (done_err == ERR_ALIGN);
  assign sat_inc[CI_DROP]  = drop_pulse;

  rxfill_free_q #(.W(OFF_W), .DEPTH(QDEPTH)) free_q_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (reg_wdata[OFF_W-1:0]),
    .pop       (q_pop),
    .flush     (q_flush),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  rxfill_engine #(
    .OFF_W       (OFF_W),
    .HDR_BYTES   (HDR_BYTES),
    .PAYLOAD_MAX (PAYLOAD_MAX),
    .LEN_W       (LEN_W),
    .PORT_CODE   (PORT_CODE)
  ) engine_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .rx_err     (rx_err),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .q_pop      (q_pop),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .done_pulse (done_pulse),
    .done_err   (done_err),
    .done_trunc (done_trunc),
    .drop_pulse (drop_pulse)
  );

  rxfill_counters #(.NSAT(N_SAT), .SAT_W(SAT_W), .TOT_W(TOT_W)) counters_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sat_inc (sat_inc),
    .sat_clr (sat_clr),
    .tot_inc (done_pulse),
    .tot_clr (tot_clr),
    .sat_val (sat_val),
    .tot_val (frame_count)
  );

  assign rxerr_count = sat_val[CI_RXERR];
  assign crc_count   = sat_val[CI_CRC];
  assign align_count = sat_val[CI_ALIGN];
  assign drop_count  = sat_val[CI_DROP];
endmodule

// File: rtl/rx_desc_fill_chk.sv
module rx_desc_fill_chk #(
  parameter int OFF_W     = 24,
  parameter int HDR_STEPS = 20,
  parameter int DESC_AW   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_last,
  input logic             mem_we,
  input logic [OFF_W-1:0] mem_addr,
  input logic [7:0]       mem_wdata,
  input logic [31:0]      frame_count,
  input logic [7:0]       drop_count
);
  logic [7:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_cnt <= '0;
    else if (rx_ready) stall_cnt <= '0;
    else               stall_cnt <= stall_cnt + 1'b1;
  end

  // R6
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rx_valid && rx_last));

  // R6
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> stall_cnt < 8'(HDR_STEPS));

  // R5
  flag_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wdata == 8'h01 && mem_addr[DESC_AW-1:0] == DESC_AW'(4)) |-> !rx_ready);

  // R3
  write_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && rx_ready && $past(rx_ready)) |-> $past(rx_valid));

  // R10
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == 8'hFF && !(reg_we && reg_addr == 3'd6)) |=> drop_count == 8'hFF);

  // R11
  drop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd6 && reg_wdata == 32'd0) |=> drop_count == 8'd0);

  // R9
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_count != $past(frame_count)) |->
      (frame_count == $past(frame_count) + 32'd1 || frame_count == 32'd0));
endmodule

bind rx_desc_fill rx_desc_fill_chk #(.OFF_W(OFF_W), .HDR_STEPS(HDR_BYTES - 4), .DESC_AW(11)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_last     (rx_last),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .frame_count (frame_count),
  .drop_count  (drop_count)
);

// File: tb/rx_desc_fill_tb_top.sv
`timescale 1ns/1ps
module rx_desc_fill_tb_top;
  localparam int MAXP = 2024;
  localparam int HDR  = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic [1:0]  rx_err = '0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [31:0] frame_count;
  logic [7:0]  rxerr_count, crc_count, align_count, drop_count;

  always #2.5 clk = ~clk;

  rx_desc_fill dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .frame_count(frame_count), .rxerr_count(rxerr_count), .crc_count(crc_count),
    .align_count(align_count), .drop_count(drop_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench models
  int        free_q[$];
  int        exp_base[$];
  int        exp_n[$];
  int        exp_len[$];
  bit [7:0]  exp_bytes[$];
  bit [7:0]  mm [int];
  int        tail_base = -100;
  int        e_frames = 0, e_rxerr = 0, e_crc = 0, e_align = 0, e_drop = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v < 255) ? v + 1 : 255;
  endfunction

  // monitor: capture memory writes and score completed descriptors
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      int a;
      a = int'(mem_addr);
      if (a >= tail_base + 5 && a <= tail_base + 7) begin
        chk(mem_wdata == 8'h00, "R5", "status upper byte", mem_wdata, 0);
      end else if (exp_base.size() == 0) begin
        chk(1'b0, "R7", "unexpected memory write addr", a, 0);
      end else begin
        int b;
        b = exp_base[0];
        if (a < b || a >= b + 2048)
          chk(1'b0, "R12", "write outside current descriptor", a, b);
        mm[a] = mem_wdata;
        if (a == b + 4 && mem_wdata == 8'h01) begin
          int n, ln;
          bit ok;
          n  = exp_n.pop_front();
          ln = exp_len.pop_front();
          void'(exp_base.pop_front());
          ok = 1;
          for (int i = 0; i < n; i++) begin
            bit [7:0] eb;
            eb = exp_bytes.pop_front();
            if (!mm.exists(b + HDR + i) || mm[b + HDR + i] != eb) ok = 0;
          end
          chk(ok, "R3", "payload bytes before flag", n, n);
          chk(!mm.exists(b + HDR + MAXP), "R8", "byte past payload area", b + HDR + MAXP, 0);
          chk(mm.exists(b + 8) && mm.exists(b + 9) &&
              {mm[b + 9], mm[b + 8]} == 16'(ln), "R4", "length field",
              {mm[b + 9], mm[b + 8]}, ln);
          chk(mm.exists(b + 10) && mm.exists(b + 11) &&
              {mm[b + 11], mm[b + 10]} == 16'h0001, "R4", "port field",
              {mm[b + 11], mm[b + 10]}, 1);
          ok = 1;
          for (int k = 12; k < 24; k++) if (!mm.exists(b + k) || mm[b + k] != 0) ok = 0;
          chk(ok, "R4", "reserved and timestamp zero", ok, 1);
          ok = 1;
          for (int k = 0; k < 4; k++) if (mm.exists(b + k)) ok = 0;
          chk(ok, "R5", "next word untouched", ok, 1);
          for (int k = 0; k < 2048; k++) if (mm.exists(b + k)) mm.delete(b + k);
          tail_base = b;
        end
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic post(input logic [31:0] w);
    reg_write(3'd0, w);
    if (w[31] && free_q.size() < 8) free_q.push_back(int'(w[23:0]));
  endtask

  task automatic flush_q();
    reg_write(3'd1, 32'h5a);
    free_q.delete();
  endtask

  // driver: pushes expected results, then streams the frame
  task automatic send_frame(input int n, input logic [1:0] e, input int seed,
                            output int stall);
    if (free_q.size() > 0) begin
      int st;
      st = (n > MAXP) ? MAXP : n;
      exp_base.push_back(free_q.pop_front());
      exp_n.push_back(st);
      exp_len.push_back(HDR + st);
      for (int i = 0; i < st; i++) exp_bytes.push_back(8'((seed + i * 7) & 8'hff));
      e_frames++;
      if (e == 2'd1) e_crc = sat_inc(e_crc);
      if (e == 2'd2) e_align = sat_inc(e_align);
      if (e == 2'd3 || n > MAXP) e_rxerr = sat_inc(e_rxerr);
    end else begin
      e_drop = sat_inc(e_drop);
    end
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'((seed + i * 7) & 8'hff);
      rx_last  = (i == n - 1);
      rx_err   = e;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    stall = 0;
    while (!rx_ready && stall < 100) begin
      stall++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic check_counters(input string req);
    chk(frame_count == 32'(e_frames), req, "frame counter", frame_count, e_frames);
    chk(rxerr_count == 8'(e_rxerr), req, "receive error counter", rxerr_count, e_rxerr);
    chk(crc_count == 8'(e_crc), req, "crc counter", crc_count, e_crc);
    chk(align_count == 8'(e_align), req, "framing counter", align_count, e_align);
    chk(drop_count == 8'(e_drop), req, "dropped counter", drop_count, e_drop);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    int st;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(rx_ready == 1'b1, "R6", "ready after reset", rx_ready, 1);
    chk(mem_we == 1'b0, "R5", "no write after reset", mem_we, 0);
    check_counters("R11");

    // R1 R12: three valid posts, one without the valid bit
    post(32'h8000_0800);
    post(32'h8000_1000);
    post(32'h8000_2000);
    post(32'h0000_3000);

    // R3 R4 R5 R6: plain frame, measure stall
    send_frame(60, 2'd0, 3, st);
    chk(st == 20, "R6", "ready low cycles after frame", st, 20);
    // R9: crc and framing codes, single-byte frame
    send_frame(64, 2'd1, 17, st);
    send_frame(1, 2'd2, 99, st);
    settle();
    check_counters("R9");

    // R1 R7: the unflagged post was ignored, so this frame drops
    send_frame(10, 2'd0, 5, st);
    settle();
    chk(st == 0, "R7", "no stall on dropped frame", st, 0);
    check_counters("R7");

    // R2: flush discards posted descriptors
    post(32'h8000_5000);
    post(32'h8000_5800);
    flush_q();
    send_frame(8, 2'd0, 9, st);
    settle();
    check_counters("R2");

    // R8: oversize frame with receive error code
    post(32'h8000_4000);
    send_frame(2030, 2'd3, 41, st);
    settle();
    check_counters("R8");

    // R1 R12 R6: nine posts with eight slots, back-to-back frames
    for (int k = 0; k < 9; k++) post(32'h8001_0000 + 32'(k * 32'h800));
    for (int k = 0; k < 9; k++) send_frame(5 + k, 2'd0, k * 13, st);
    settle();
    check_counters("R1");

    // R11: nonzero clear ignored, zero clear works
    reg_write(3'd6, 32'h5);
    @(negedge clk);
    chk(drop_count == 8'(e_drop), "R11", "nonzero clear ignored", drop_count, e_drop);
    reg_write(3'd6, 32'h0);
    e_drop = 0;
    reg_write(3'd4, 32'h0);
    e_crc = 0;
    reg_write(3'd2, 32'h0);
    e_frames = 0;
    @(negedge clk);
    check_counters("R11");

    // R10: saturation of the dropped counter
    for (int k = 0; k < 260; k++) send_frame(1, 2'd0, k, st);
    settle();
    chk(drop_count == 8'd255, "R10", "dropped counter saturates", drop_count, 255);
    check_counters("R10");

    chk(exp_base.size() == 0, "R5", "all stored frames flagged", exp_base.size(), 0);
    finish_run();
  end
endmodule